// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the configuration-space front end of a multi-function peripheral controller. It sits on a byte-wide host I/O bus with simple one-cycle read and write strobes. It answers at two adjacent addresses. The lower one is the index port and the upper one is the data port. A strap input places the pair at one of two base addresses.

Configuration space stays locked until the host writes the enter key to the index port twice in a row. Once unlocked, the host writes a register number to the index port, then reads or writes that register through the data port. Read-modify-write works because every data-port read returns the live register value. Indices below 0x30 hold global registers: a logical-device selector, a read-only two-byte chip identifier and a few shared scratch registers. Indices from 0x30 upward reach a bank of registers that belongs to the logical device chosen by the selector. Writing the exit key to the index port locks the space again.

Top module: `keyed_cfg_port`

## Requirements
- R1: With `strap_hi`=0 the index port is at 0x2E and the data port at 0x2F. With `strap_hi`=1 they are at 0x4E and 0x4F. A read at any other address returns 0xFF, and a write there changes nothing. While unlocked, an index-port read returns the current index.
- R2: The space unlocks only after 0x87 has been written to the index port on two consecutive index-port writes.
- R3: If an index-port write of any value other than 0x87 falls between the two 0x87 writes, the key sequence starts over, so the space stays locked.
- R4: While unlocked, writing 0xAA to the index port locks the space.
- R5: While locked, data-port writes are ignored. Data-port and index-port reads return 0xFF.
- R6: Index 0x20 reads the high byte and index 0x21 the low byte of a 16-bit identifier. Its upper 12 bits are 0xA23 and its low 4 bits are the revision (default 1), so the two bytes read 0xA2 and 0x31. Writes to these indices are discarded.
- R7: Index 0x07 is a readable and writable logical-device selector (reset 0). Its value chooses which device bank indices 0x30 and above reach.
- R8: Indices 0x22 to 0x25 are global scratch registers (reset 0x00). They read back the last value written whatever the selector holds.
- R9: Each of the 4 device banks holds 8 registers at indices 0x30 to 0x37 (reset 0x00). Each bank keeps its own values, and a data-port read returns the current value, so a read-modify-write sequence works.
- R10: Indices that are not implemented read 0x00 and ignore writes. This covers banked indices while the selector holds 4 or more.
- R11: Read data appears on `bus_rdata` on the clock edge that samples the read strobe. It holds its value until the next read strobe.
- R12: After reset the space is locked, the index and the selector are 0, and `bus_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_hi | input | 1 | Base select: 0 gives 0x2E/0x2F, 1 gives 0x4E/0x4F |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The assertions take for granted that the host never raises the read and write strobes in the same cycle. They also assume `strap_hi` only changes while no access is in flight, and one checker assertion states the first of these assumptions directly. The bench drives every access through one write task or one read task. Each task raises exactly one strobe for one clock, and the strap is changed only between tasks. Under these conditions the checks on unlock, exit, locked reads and chip-ID reads can be stated cycle by cycle.

// File: rtl/cfgp_pkg.sv
// Shared constants and types for the keyed configuration port.
// Assumes byte-wide register space with 8-bit indices.
package cfgp_pkg;
    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_ARMED  = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_t;

    localparam logic [7:0] KEY_ENTER  = 8'h87;
    localparam logic [7:0] KEY_EXIT   = 8'hAA;
    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_ID_HI  = 8'h20;
    localparam logic [7:0] IDX_ID_LO  = 8'h21;
    localparam logic [7:0] BANK_START = 8'h30;
    localparam logic [7:0] RD_IDLE    = 8'hFF;
endpackage

// File: rtl/cfgp_unlock.sv
// Key sequencer and index register.
// Watches index-port writes: two consecutive enter keys unlock the space,
// the exit key locks it, and other writes while unlocked load the index.
// Assumes idx_wr is a single-cycle strobe qualified by the address decode.
module cfgp_unlock
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open_o,
    output logic [7:0] index_o
);
    key_state_t state_q;
    logic [7:0] index_q;

    // Advance the key sequence on each index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KEY_LOCKED;
        end else if (idx_wr) begin
            case (state_q)
                KEY_LOCKED: state_q <= (wdata == KEY_ENTER) ? KEY_ARMED : KEY_LOCKED;
                KEY_ARMED:  state_q <= (wdata == KEY_ENTER) ? KEY_OPEN  : KEY_LOCKED;
                KEY_OPEN:   state_q <= (wdata == KEY_EXIT)  ? KEY_LOCKED : KEY_OPEN;
                default:    state_q <= KEY_LOCKED;
            endcase
        end
    end

    // Load the register index from index-port writes made while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
        end else if (idx_wr && state_q == KEY_OPEN && wdata != KEY_EXIT) begin
            index_q <= wdata;
        end
    end

    assign open_o  = (state_q == KEY_OPEN);
    assign index_o = index_q;
endmodule

// File: rtl/cfgp_global.sv
// Global register file for indices below the banked area: the logical
// device selector, the read-only identifier and a run of scratch bytes.
// Assumes GLB_FIRST..GLB_FIRST+NUM_GLB-1 avoids the selector and ID indices
// and stays below the banked start.
module cfgp_global
    import cfgp_pkg::*;
#(
    parameter int          NUM_GLB     = 4,
    parameter logic [7:0]  GLB_FIRST   = 8'h22,
    parameter logic [11:0] CHIP_FAMILY = 12'hA23,
    parameter logic [3:0]  CHIP_REV    = 4'h1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output logic [7:0] ldn_o,
    output logic       hit_o,
    output logic [7:0] rd_val_o
);
    localparam logic [15:0] CHIP_ID = {CHIP_FAMILY, CHIP_REV};

    logic [7:0] ldn_q;
    logic [7:0] scr [NUM_GLB];

    // Hold the logical-device selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn_q <= 8'h00;
        end else if (wr_en && index == IDX_LDN) begin
            ldn_q <= wdata;
        end
    end

    // One scratch byte per generated slot.
    for (genvar g = 0; g < NUM_GLB; g++) begin : g_scr
        logic [7:0] q;
        // Capture writes addressed to this scratch slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 8'h00;
            end else if (wr_en && index == GLB_FIRST + 8'(g)) begin
                q <= wdata;
            end
        end
        assign scr[g] = q;
    end

    // Select the read value for the current index and flag whether it exists.
    always_comb begin
        hit_o    = 1'b0;
        rd_val_o = 8'h00;
        if (index == IDX_LDN) begin
            hit_o    = 1'b1;
            rd_val_o = ldn_q;
        end else if (index == IDX_ID_HI) begin
            hit_o    = 1'b1;
            rd_val_o = CHIP_ID[15:8];
        end else if (index == IDX_ID_LO) begin
            hit_o    = 1'b1;
            rd_val_o = CHIP_ID[7:0];
        end else begin
            for (int i = 0; i < NUM_GLB; i++) begin
                if (index == GLB_FIRST + 8'(i)) begin
                    hit_o    = 1'b1;
                    rd_val_o = scr[i];
                end
            end
        end
    end

    assign ldn_o = ldn_q;
endmodule

// File: rtl/cfgp_banks.sv
// Per-device register banks reached at indices from the banked start upward.
// The selector picks the bank; a selector beyond NUM_DEV maps to nothing.
// Assumes NUM_DEV and BANK_REGS are at least 2 and at most 256 - 0x30.
module cfgp_banks
    import cfgp_pkg::*;
#(
    parameter int NUM_DEV   = 4,
    parameter int BANK_REGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] ldn,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output logic       hit_o,
    output logic [7:0] rd_val_o
);
    localparam int DEV_W = $clog2(NUM_DEV);
    localparam int REG_W = $clog2(BANK_REGS);
    localparam logic [7:0] NUM_DEV_B   = 8'(NUM_DEV);
    localparam logic [7:0] BANK_REGS_B = 8'(BANK_REGS);

    logic [7:0] mem [NUM_DEV][BANK_REGS];
    logic [7:0] off;
    logic       dev_ok;
    logic       reg_ok;

    assign off    = index - BANK_START;
    assign dev_ok = (ldn < NUM_DEV_B);
    assign reg_ok = (index >= BANK_START) && (off < BANK_REGS_B);
    assign hit_o  = dev_ok && reg_ok;

    // Store writes into the selected device's register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < NUM_DEV; d++) begin
                for (int r = 0; r < BANK_REGS; r++) begin
                    mem[d][r] <= 8'h00;
                end
            end
        end else if (wr_en && hit_o) begin
            mem[ldn[DEV_W-1:0]][off[REG_W-1:0]] <= wdata;
        end
    end

    // Return the live value of the addressed banked register.
    always_comb begin
        rd_val_o = 8'h00;
        if (hit_o) begin
            rd_val_o = mem[ldn[DEV_W-1:0]][off[REG_W-1:0]];
        end
    end
endmodule

// File: rtl/keyed_cfg_port.sv
// Top of the keyed configuration port. Decodes the index/data address
// pair, gates data access with the key sequencer and registers read data.
// Assumes read and write strobes are never active together.
module keyed_cfg_port
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_LO = 'h2E,
    parameter logic [ADDR_W-1:0] BASE_HI = 'h4E,
    parameter int          NUM_DEV     = 4,
    parameter int          BANK_REGS   = 8,
    parameter int          NUM_GLB     = 4,
    parameter logic [7:0]  GLB_FIRST   = 8'h22,
    parameter logic [11:0] CHIP_FAMILY = 12'hA23,
    parameter logic [3:0]  CHIP_REV    = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hi,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    logic [ADDR_W-1:0] base;
    logic idx_sel, dat_sel;
    logic cfg_open;
    logic [7:0] cur_index;
    logic [7:0] ldn;
    logic data_wr;
    logic glb_hit, bnk_hit;
    logic [7:0] glb_val, bnk_val, reg_val;
    logic [7:0] rdata_q;

    assign base    = strap_hi ? BASE_HI : BASE_LO;
    assign idx_sel = (bus_addr == base);
    assign dat_sel = (bus_addr == base + ADDR_W'(1));
    assign data_wr = bus_wr && dat_sel && cfg_open;

    cfgp_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (bus_wr && idx_sel),
        .wdata   (bus_wdata),
        .open_o  (cfg_open),
        .index_o (cur_index)
    );

    cfgp_global #(
        .NUM_GLB     (NUM_GLB),
        .GLB_FIRST   (GLB_FIRST),
        .CHIP_FAMILY (CHIP_FAMILY),
        .CHIP_REV    (CHIP_REV)
    ) u_global (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_wr),
        .index    (cur_index),
        .wdata    (bus_wdata),
        .ldn_o    (ldn),
        .hit_o    (glb_hit),
        .rd_val_o (glb_val)
    );

    cfgp_banks #(
        .NUM_DEV   (NUM_DEV),
        .BANK_REGS (BANK_REGS)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_wr),
        .ldn      (ldn),
        .index    (cur_index),
        .wdata    (bus_wdata),
        .hit_o    (bnk_hit),
        .rd_val_o (bnk_val)
    );

    // Merge the two register sources; unimplemented indices read zero.
    always_comb begin
        if (glb_hit)      reg_val = glb_val;
        else if (bnk_hit) reg_val = bnk_val;
        else              reg_val = 8'h00;
    end

    // Capture read data on each read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= RD_IDLE;
        end else if (bus_rd) begin
            if (idx_sel)      rdata_q <= cfg_open ? cur_index : RD_IDLE;
            else if (dat_sel) rdata_q <= cfg_open ? reg_val : RD_IDLE;
            else              rdata_q <= RD_IDLE;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/keyed_cfg_port_chk.sv
// Checker for keyed_cfg_port, attached by bind. Recomputes the address
// window from the strap on its own and relates bus traffic to the
// sequencer state and the read data over time.
module keyed_cfg_port_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_LO = 'h2E,
    parameter logic [ADDR_W-1:0] BASE_HI = 'h4E,
    parameter logic [11:0] CHIP_FAMILY = 12'hA23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strap_hi,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              cfg_open,
    input logic [7:0]        cur_index
);
    logic at_idx, at_dat;
    assign at_idx = strap_hi ? (bus_addr == BASE_HI) : (bus_addr == BASE_LO);
    assign at_dat = strap_hi ? (bus_addr == BASE_HI + ADDR_W'(1))
                             : (bus_addr == BASE_LO + ADDR_W'(1));

    // Input assumption: never both strobes at once.
    a_bus_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R1: reads outside the window return the idle value.
    a_r1_outside_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !at_idx && !at_dat) |=> (bus_rdata == 8'hFF));

    // R2: unlocking always follows an enter key written to the index port.
    a_r2_unlock_by_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr && at_idx && bus_wdata == 8'h87));

    // R4: exit key locks the space.
    a_r4_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && at_idx && bus_wdata == 8'hAA) |=> !cfg_open);

    // R5: locked data reads return the idle value.
    a_r5_locked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_rd && at_dat) |=> (bus_rdata == 8'hFF));

    // R6: identifier high byte comes back on a data read of its index.
    a_r6_id_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_rd && at_dat && cur_index == 8'h20)
        |=> (bus_rdata == CHIP_FAMILY[11:4]));

    // R11: read data holds while no read strobe is seen.
    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
    .ADDR_W      (ADDR_W),
    .BASE_LO     (BASE_LO),
    .BASE_HI     (BASE_HI),
    .CHIP_FAMILY (CHIP_FAMILY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_hi  (strap_hi),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_open  (cfg_open),
    .cur_index (cur_index)
);

// File: tb/keyed_cfg_port_tb_top.sv
// Directed bench for keyed_cfg_port: one task per scenario.
module keyed_cfg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_hi = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int failures = 0;
    logic [15:0] ib = 16'h2E;

    always #4 clk = ~clk;

    keyed_cfg_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_hi  (strap_hi),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic unlock();
        wr(ib, 8'h87); wr(ib, 8'h87);
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        wr(ib, idx); wr(ib + 16'd1, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
        wr(ib, idx); rd(ib + 16'd1, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R12 reset rdata", bus_rdata, 8'hFF);
        rd(16'h2F, v); check("R12 locked after reset data read", v, 8'hFF);
        rd(16'h2E, v); check("R5 locked index read", v, 8'hFF);
    endtask

    task automatic t_unlock_id();
        logic [7:0] v;
        unlock();
        rd(ib, v); check("R12 index resets to 0", v, 8'h00);
        reg_rd(8'h07, v); check("R12 selector resets to 0", v, 8'h00);
        reg_rd(8'h20, v); check("R2/R6 id high", v, 8'hA2);
        reg_rd(8'h21, v); check("R6 id low", v, 8'h31);
        reg_wr(8'h20, 8'h00); rd(ib + 16'd1, v); check("R6 id high read-only", v, 8'hA2);
        reg_wr(8'h21, 8'hFF); rd(ib + 16'd1, v); check("R6 id low read-only", v, 8'h31);
    endtask

    task automatic t_exit_and_ignore();
        logic [7:0] v;
        reg_wr(8'h22, 8'h3C);
        wr(ib, 8'hAA);
        rd(ib + 16'd1, v); check("R4 locked after exit key", v, 8'hFF);
        wr(ib + 16'd1, 8'h55);
        unlock();
        rd(ib, v); check("R4 exit key not loaded as index", v, 8'h22);
        rd(ib + 16'd1, v); check("R5 locked write ignored", v, 8'h3C);
    endtask

    task automatic t_restart();
        logic [7:0] v;
        wr(ib, 8'hAA);
        wr(ib, 8'h87); wr(ib, 8'h12); wr(ib, 8'h87);
        rd(ib + 16'd1, v); check("R3 interrupted key stays locked", v, 8'hFF);
        wr(ib, 8'h87);
        wr(ib, 8'h20); rd(ib + 16'd1, v); check("R2 two consecutive keys unlock", v, 8'hA2);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        reg_wr(8'h07, 8'h00); reg_wr(8'h30, 8'h11);
        reg_wr(8'h07, 8'h01); reg_wr(8'h30, 8'h22);
        reg_rd(8'h07, v); check("R7 selector readback", v, 8'h01);
        reg_rd(8'h30, v); check("R9 bank1 value", v, 8'h22);
        reg_wr(8'h07, 8'h00);
        reg_rd(8'h30, v); check("R7/R9 bank0 kept separate", v, 8'h11);
        reg_wr(8'h37, 8'h40);
        reg_rd(8'h37, v);
        wr(ib + 16'd1, v | 8'h05);
        rd(ib + 16'd1, v); check("R9 read-modify-write", v, 8'h45);
    endtask

    task automatic t_global();
        logic [7:0] v;
        reg_wr(8'h07, 8'h00); reg_wr(8'h25, 8'h5A);
        reg_wr(8'h07, 8'h02);
        reg_rd(8'h25, v); check("R8 scratch shared across selector", v, 8'h5A);
        reg_rd(8'h22, v); check("R8 scratch low slot", v, 8'h3C);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        reg_wr(8'h10, 8'h77); rd(ib + 16'd1, v); check("R10 unimplemented global", v, 8'h00);
        reg_wr(8'h38, 8'h77); rd(ib + 16'd1, v); check("R10 past bank end", v, 8'h00);
        reg_wr(8'h07, 8'h07); reg_wr(8'h30, 8'h99);
        rd(ib + 16'd1, v); check("R10 selector out of range", v, 8'h00);
        reg_wr(8'h07, 8'h00);
        reg_rd(8'h30, v); check("R10 stray write hit no bank", v, 8'h11);
    endtask

    task automatic t_strap();
        logic [7:0] v;
        strap_hi = 1'b1; ib = 16'h4E;
        rd(16'h2F, v); check("R1 old base no longer decoded", v, 8'hFF);
        wr(16'h4E, 8'h20); rd(16'h4F, v); check("R1 high base data port", v, 8'hA2);
        rd(16'h4E, v); check("R1 index readback", v, 8'h20);
        wr(16'h4E, 8'h23); wr(16'h2F, 8'hEE); wr(16'h1234, 8'hEE);
        rd(16'h4F, v); check("R1 writes outside window ignored", v, 8'h00);
        repeat (3) @(negedge clk);
        check("R11 rdata holds without strobe", bus_rdata, 8'h00);
        @(negedge clk); bus_addr = 16'h4E; bus_rd = 1'b1;
        #1 check("R11 rdata not updated before edge", bus_rdata, 8'h00);
        @(negedge clk); bus_rd = 1'b0;
        check("R11 rdata updated at edge", bus_rdata, 8'h23);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlock_id();
        t_exit_and_ignore();
        t_restart();
        t_banks();
        t_global();
        t_unimpl();
        t_strap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule